// File: doc/BRIEF.md
# Output Impedance Calibration Sequencer

This block holds the binary-weighted strength code for an output driver and keeps it near its best value. A free-running interval counter marks the end of each evaluation period. At that boundary the block samples a comparator result that says whether the driver is too weak (`cmp_up` high) or too strong (`cmp_up` low). It then moves the code one step in that direction, without ever wrapping past either end of the code range.

The code is only changed through a registered update strobe, one cycle after the sample. The driver therefore sees one clean transition at a cycle boundary and never sees a glitching code. A separate start-up counter holds the calibrated flag low for a fixed settling window after reset. The flag rises when that window expires and stays high. Evaluation runs before and after the flag rises, so the code keeps following supply and temperature drift during normal operation.

Top module: `zq_cal_seq`

## Requirements
- R1: While reset is held and directly after it is released, `imp_code` equals INIT_CODE (default 16), and `eval_stb` and `cal_done` are 0.
- R2: `eval_stb` is high for exactly one cycle, in the cycle after every INTERVAL-th rising edge counted from reset release (default INTERVAL = 64). It is low in every other cycle.
- R3: `cmp_up` is sampled only on the rising edge that ends an interval, which is the edge just before `eval_stb` goes high. Its value on any other edge has no effect on `imp_code`.
- R4: Each evaluation moves the code by one step. A sampled `cmp_up` of 1 adds one and a sampled 0 subtracts one. The new code appears on the rising edge that ends the `eval_stb` cycle.
- R5: `imp_code` holds its value on every rising edge that does not end an `eval_stb` cycle.
- R6: An upward step from all-ones (31 at the default CODE_W = 5) leaves the code at all-ones.
- R7: A downward step from zero leaves the code at zero.
- R8: `cal_done` becomes 1 after STARTUP rising edges from reset release (default 32768), whatever `cmp_up` does. Once set, it stays 1 until reset.
- R9: Evaluations and code steps continue in the same way after `cal_done` has risen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_up | input | 1 | Comparator result: 1 = driver too weak, 0 = driver too strong |
| imp_code | output | CODE_W | Binary-weighted driver strength code |
| eval_stb | output | 1 | One-cycle strobe that announces an update of `imp_code` |
| cal_done | output | 1 | Start-up settling window has expired (sticky) |

## Verification
The hardest case to reach is a step that is pushed against a saturated end of the code range while `cmp_up` flips on every cycle between samples. The stimulus holds one direction for about twenty evaluations to pin the code at all-ones, then holds the other direction to pin it at zero. On every edge that is not a sample edge it drives the opposite of the intended direction, so that a sample taken on the wrong edge shows up at once. The run then continues past the 32768-cycle settling window, which checks that the flag is sticky and that stepping carries on after it rises.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } zq_dir_e;

  // One saturating step of a code in the range 0..top.
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input int unsigned top,
                                           input zq_dir_e dir);
    if (dir == DIR_UP)
      return (cur >= top) ? top : cur + 1;
    else
      return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/zq_ivl_timer.sv
module zq_ivl_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic fire
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign fire = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (fire) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/zq_startup_timer.sv
module zq_startup_timer #(
  parameter int STARTUP = 32768
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(STARTUP + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/zq_code_reg.sv
module zq_code_reg
  import zq_cal_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int INIT_CODE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              cmp_up,
  output logic              stb,
  output logic [CODE_W-1:0] code
);
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

  zq_dir_e           dir_q;
  logic [CODE_W-1:0] code_nxt;

  always_comb code_nxt = CODE_W'(sat_step(int'(code), CODE_MAX, dir_q));

  // Stage 1: capture direction at the interval boundary, raise strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= DIR_DOWN;
      stb   <= 1'b0;
    end else begin
      stb <= fire;
      if (fire) dir_q <= cmp_up ? DIR_UP : DIR_DOWN;
    end
  end

  // Stage 2: apply the step at the edge that ends the strobe cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)   code <= CODE_W'(INIT_CODE);
    else if (stb) code <= code_nxt;
  end
endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq #(
  parameter int CODE_W    = 5,
  parameter int INIT_CODE = 16,
  parameter int INTERVAL  = 64,
  parameter int STARTUP   = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_up,
  output logic [CODE_W-1:0] imp_code,
  output logic              eval_stb,
  output logic              cal_done
);
  logic ivl_fire;

  zq_ivl_timer #(.INTERVAL(INTERVAL)) u_ivl (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (ivl_fire)
  );

  zq_startup_timer #(.STARTUP(STARTUP)) u_su (
    .clk  (clk),
    .rst_n(rst_n),
    .done (cal_done)
  );

  zq_code_reg #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_code (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (ivl_fire),
    .cmp_up(cmp_up),
    .stb   (eval_stb),
    .code  (imp_code)
  );
endmodule

// File: rtl/zq_cal_chk.sv
module zq_cal_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_up,
  input logic [CODE_W-1:0] imp_code,
  input logic              eval_stb,
  input logic              cal_done,
  input logic              ivl_fire
);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R2: boundary event is followed by the strobe
  a_r2_fire_to_stb: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_fire |=> eval_stb);

  // R2: strobe lasts a single cycle
  a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> !eval_stb);

  // R5: code holds when no strobe
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb |=> $stable(imp_code));

  // R4: at most one step per evaluation
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> (imp_code == $past(imp_code)) ||
                 (imp_code == $past(imp_code) + 1'b1) ||
                 (imp_code == $past(imp_code) - 1'b1));

  // R6: no wrap from all-ones
  a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && imp_code == TOP) |=> imp_code != '0);

  // R7: no wrap from zero
  a_r7_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && imp_code == '0) |=> imp_code != TOP);

  // R8: calibrated flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  // R1: reset values on the first cycle after reset
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (!eval_stb && !cal_done));

  logic unused_in;
  assign unused_in = cmp_up;
endmodule

bind zq_cal_seq zq_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmp_up  (cmp_up),
  .imp_code(imp_code),
  .eval_stb(eval_stb),
  .cal_done(cal_done),
  .ivl_fire(ivl_fire)
);

// File: tb/sim_zq_cal_seq.sv
module sim_zq_cal_seq;
  localparam int W     = 5;
  localparam int INIT  = 16;
  localparam int IVL   = 64;
  localparam int SU    = 32768;
  localparam int EDGES = 34000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmp_up = 1'b0;
  logic [W-1:0] imp_code;
  logic         eval_stb;
  logic         cal_done;

  int total = 0;
  int bad = 0;
  int ecount = 0;
  bit running = 0;
  bit finished = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  zq_cal_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmp_up(cmp_up),
    .imp_code(imp_code), .eval_stb(eval_stb), .cal_done(cal_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, ecount);
    end
  endtask

  // direction chosen for evaluation number e
  function automatic bit plan_dir(input int e);
    if (e < 20) return 1'b1;
    if (e < 60) return 1'b0;
    if (e < 300) return (e % 3) != 0;
    return e[0];
  endfunction

  // monitor: pops expectations one cycle after each strobe
  bit stb_prev = 0;
  int code_prev = INIT;
  always @(negedge clk) begin
    if (running) begin
      if (stb_prev) begin
        int e;
        string tag;
        e = exp_q.pop_front();
        if (ecount > SU)       tag = "R9";
        else if (e == 31)      tag = "R6";
        else if (e == 0)       tag = "R7";
        else                   tag = "R4 R3";
        check(int'(imp_code) == e, tag, int'(imp_code), e);
      end else begin
        check(int'(imp_code) == code_prev, "R5", int'(imp_code), code_prev);
      end
      stb_prev  = eval_stb;
      code_prev = int'(imp_code);
    end
  end

  initial begin
    int model;
    int evals;
    model = INIT;
    evals = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(int'(imp_code) == INIT, "R1", int'(imp_code), INIT);
    check(eval_stb == 1'b0, "R1", int'(eval_stb), 0);
    check(cal_done == 1'b0, "R1", int'(cal_done), 0);
    cmp_up = ~plan_dir(0);
    rst_n  = 1'b1;
    running = 1;
    for (int n = 1; n <= EDGES; n++) begin
      bit samp;
      @(posedge clk);
      ecount = n;
      if (n % IVL == 0) begin
        // driver: expected code from the sampled direction
        if (cmp_up) model = (model == 31) ? 31 : model + 1;
        else        model = (model == 0) ? 0 : model - 1;
        exp_q.push_back(model);
        evals++;
      end
      @(negedge clk);
      samp = ((n % IVL) == 0) && (n > 0);
      check(eval_stb == samp, "R2", int'(eval_stb), int'(samp));
      check(cal_done == (n >= SU), "R8", int'(cal_done), int'(n >= SU));
      // R3: off-sample edges see the opposite of the intended direction
      if (((n + 1) % IVL) == 0) cmp_up = plan_dir(evals);
      else                      cmp_up = ~plan_dir(evals);
    end
    running = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", ecount, EDGES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule